// File: doc/BRIEF.md
# Isolated PWM Pulse-Transformer Encoder

This block sits on the secondary side of an isolated forward converter. It produces two complementary drive lines for a small pulse transformer. Through that one transformer the primary side receives its switch timing and its bias power. It also produces the enable signals for the secondary forward and synchronous rectifier gates.

In encoded operation the drive pair carries a near-constant 50% square wave, which keeps the transformer's volt-seconds balanced. A switching cycle starts with a positive half (line A high, line B low). That half lasts until the maximum-duty point, after which the negative half follows. The end of the forward on-time is marked by a short notch in the positive half, during which both lines are low. In standard operation, line A carries the plain PWM on-time and line B carries a reference clock in phase with it.

An oscillator tick starts each cycle. A current comparator issues the terminate request. Fault and overvoltage inputs override the normal timing.

Top module: `pt_encoder`

## Requirements
- R1: After synchronous reset, all four outputs are low. They stay low until the first cycle tick, provided no overvoltage is flagged.
- R2: Consider a tick sampled with no terminate, overcurrent or overvoltage present. One cycle later the forward gate is high. In encoded mode the drive pair also reads A=1, B=0 at that point.
- R3: In encoded mode, line A and line B are never both high. From the maximum-duty point until the next tick the pair reads A=0, B=1.
- R4: The maximum-duty point is the output change on the clock edge PERIOD_CLKS/2 edges after the tick edge (50% mode, dmax75_sel=0) or 3*PERIOD_CLKS/4 edges after it (75% mode, dmax75_sel=1). If no terminate has arrived, the forward gate falls there and no notch precedes the change.
- R5: Consider a terminate sampled while the forward gate is high in the positive half. One cycle later the forward gate is low. In encoded mode both drive lines are then low for NOTCH_CLKS cycles, after which line A returns high until the maximum-duty point.
- R6: A terminate sampled together with the tick gives 0% duty. The forward gate stays low, and in encoded mode the notch starts at the beginning of the cycle.
- R7: A terminate arriving after the on-time has already ended in the same cycle has no effect. No second notch is produced.
- R8: enc_sel (1 = encoded) and dmax75_sel are sampled only on the tick edge. Changes to them between ticks take effect at the next cycle.
- R9: In standard mode, line A equals the forward gate. Line B is high from the tick until PERIOD_CLKS/2 edges after it, then low.
- R10: The synchronous gate rises one cycle after sw_neg is sampled high while the forward gate is already low in a running cycle. It holds until the next tick and is never high together with the forward gate.
- R11: One cycle after overvoltage is sampled, the synchronous gate is high and the forward gate is low. The condition is not latched: the first tick after it clears restarts normal on-time.
- R12: An overcurrent acts as an immediate terminate: one cycle later the forward gate is low. At a tick it forces 0% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock pulse that starts a switching cycle |
| term_req | input | 1 | Terminate request from the current comparator |
| enc_sel | input | 1 | 1 = encoded drive, 0 = standard PWM plus reference clock |
| dmax75_sel | input | 1 | 1 = 75% maximum duty, 0 = 50% |
| ov_flag | input | 1 | Output overvoltage indication |
| oc_flag | input | 1 | Overcurrent fault indication |
| sw_neg | input | 1 | Switch node has fallen below zero |
| pt_a | output | 1 | Pulse-transformer drive line A |
| pt_b | output | 1 | Pulse-transformer drive line B |
| fwd_gate | output | 1 | Forward rectifier gate enable |
| syn_gate | output | 1 | Synchronous rectifier gate enable |

## Verification
Every output is a register loaded from inputs sampled on a single edge, so each response is due exactly one clock after its cause. Time-based results fall on edges counted from the tick edge: the maximum-duty change on edge PERIOD_CLKS/2 or 3*PERIOD_CLKS/4, and the notch end NOTCH_CLKS edges after the terminate. The bench drives inputs at the falling edge and samples 1 ns after each rising edge. It keeps a cycle index since the last tick and places each directed check on the exact index where a change is due, with neighbouring indices checked to catch one-off errors. A per-cycle model compares all four outputs during the random phase.

// File: rtl/pte_pkg.sv
package pte_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_POS = 2'd1, PH_NEG = 2'd2} phase_t;
endpackage

// File: rtl/pte_timer.sv
module pte_timer
  import pte_pkg::*;
#(
  parameter int PERIOD_CLKS = 1000
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   enc_in,
  input  logic   d75_in,
  output phase_t phase_q,
  output phase_t phase_d,
  output logic   ref_d,
  output logic   enc_d,
  output logic   dmax_hit
);
  localparam int CW = $clog2(PERIOD_CLKS + 1);
  localparam logic [CW-1:0] CSAT = CW'(PERIOD_CLKS);
  localparam logic [CW-1:0] D50  = CW'(PERIOD_CLKS / 2);
  localparam logic [CW-1:0] D75  = CW'((PERIOD_CLKS * 3) / 4);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          enc_q, d75_q, d75_d, ref_q;

  always_comb begin
    if (tick) begin
      cnt_d = '0;
      enc_d = enc_in;
      d75_d = d75_in;
    end else begin
      cnt_d = (cnt_q == CSAT) ? cnt_q : cnt_q + 1'b1;
      enc_d = enc_q;
      d75_d = d75_q;
    end
    dmax_hit = !tick && (phase_q == PH_POS) && (cnt_d == (d75_q ? D75 : D50));
    if (tick)          phase_d = PH_POS;
    else if (dmax_hit) phase_d = PH_NEG;
    else               phase_d = phase_q;
    if (tick)              ref_d = 1'b1;
    else if (cnt_d == D50) ref_d = 1'b0;
    else                   ref_d = ref_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= CSAT;
      enc_q   <= 1'b0;
      d75_q   <= 1'b0;
      ref_q   <= 1'b0;
      phase_q <= PH_IDLE;
    end else begin
      cnt_q   <= cnt_d;
      enc_q   <= enc_d;
      d75_q   <= d75_d;
      ref_q   <= ref_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/pte_gates.sv
module pte_gates
  import pte_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   term_e,
  input  logic   ov,
  input  logic   sw_neg,
  input  logic   dmax_hit,
  input  phase_t phase_q,
  output logic   fwd_q,
  output logic   fwd_d,
  output logic   syn_q,
  output logic   stop_evt
);
  logic syn_d;

  always_comb begin
    if (tick) begin
      stop_evt = term_e;
      fwd_d    = !term_e;
    end else begin
      stop_evt = fwd_q && term_e && !dmax_hit;
      fwd_d    = fwd_q && !term_e && !dmax_hit;
    end
    if (ov)                                           syn_d = 1'b1;
    else if (tick)                                    syn_d = 1'b0;
    else if (!fwd_q && sw_neg && phase_q != PH_IDLE)  syn_d = 1'b1;
    else                                              syn_d = syn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q <= 1'b0;
      syn_q <= 1'b0;
    end else begin
      fwd_q <= fwd_d;
      syn_q <= syn_d;
    end
  end

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst) !(fwd_q && syn_q));
  a_r12_oc_kill: assert property (@(posedge clk) disable iff (rst) (term_e && !tick) |=> !fwd_q);
endmodule

// File: rtl/pte_notch.sv
module pte_notch #(
  parameter int NOTCH_CLKS = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic stop_evt,
  input  logic enc_d,
  input  logic dmax_hit,
  output logic notch_d
);
  localparam int NW = $clog2(NOTCH_CLKS + 1);
  localparam logic [NW-1:0] NLOAD = NW'(NOTCH_CLKS);

  logic [NW-1:0] ncnt_q, ncnt_d;

  always_comb begin
    if (dmax_hit)                ncnt_d = '0;
    else if (stop_evt && enc_d)  ncnt_d = NLOAD;
    else if (tick)               ncnt_d = '0;
    else if (ncnt_q != '0)       ncnt_d = ncnt_q - 1'b1;
    else                         ncnt_d = '0;
    notch_d = (ncnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) ncnt_q <= '0;
    else     ncnt_q <= ncnt_d;
  end

  a_r5_notch_bounded: assert property (@(posedge clk) disable iff (rst) (ncnt_q != '0) |-> (ncnt_q <= NLOAD));
endmodule

// File: rtl/pt_encoder.sv
module pt_encoder
  import pte_pkg::*;
#(
  parameter int PERIOD_CLKS = 1000,
  parameter int NOTCH_CLKS  = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_tick,
  input  logic term_req,
  input  logic enc_sel,
  input  logic dmax75_sel,
  input  logic ov_flag,
  input  logic oc_flag,
  input  logic sw_neg,
  output logic pt_a,
  output logic pt_b,
  output logic fwd_gate,
  output logic syn_gate
);
  phase_t phase_q, phase_d;
  logic   ref_d, enc_d, dmax_hit, fwd_d, stop_evt, notch_d, term_e;

  assign term_e = term_req | oc_flag | ov_flag;

  pte_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
    .clk(clk), .rst(rst), .tick(cyc_tick), .enc_in(enc_sel), .d75_in(dmax75_sel),
    .phase_q(phase_q), .phase_d(phase_d), .ref_d(ref_d), .enc_d(enc_d), .dmax_hit(dmax_hit)
  );

  pte_gates u_gates (
    .clk(clk), .rst(rst), .tick(cyc_tick), .term_e(term_e), .ov(ov_flag), .sw_neg(sw_neg),
    .dmax_hit(dmax_hit), .phase_q(phase_q), .fwd_q(fwd_gate), .fwd_d(fwd_d),
    .syn_q(syn_gate), .stop_evt(stop_evt)
  );

  pte_notch #(.NOTCH_CLKS(NOTCH_CLKS)) u_notch (
    .clk(clk), .rst(rst), .tick(cyc_tick), .stop_evt(stop_evt), .enc_d(enc_d),
    .dmax_hit(dmax_hit), .notch_d(notch_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_a <= 1'b0;
      pt_b <= 1'b0;
    end else if (enc_d) begin
      pt_a <= (phase_d == PH_POS) && !notch_d;
      pt_b <= (phase_d == PH_NEG);
    end else begin
      pt_a <= fwd_d;
      pt_b <= ref_d;
    end
  end

  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (cyc_tick && enc_sel && !term_req && !oc_flag && !ov_flag) |=> (fwd_gate && pt_a && !pt_b));
  a_r11_ov_force: assert property (@(posedge clk) disable iff (rst)
    ov_flag |=> (syn_gate && !fwd_gate));
  a_r12_oc_off: assert property (@(posedge clk) disable iff (rst)
    oc_flag |=> !fwd_gate);
endmodule

// File: tb/test_pt_encoder.sv
`timescale 1ns/100ps
module test_pt_encoder;
  localparam int P   = 48;
  localparam int N   = 4;
  localparam int D50 = P / 2;
  localparam int D75 = (P * 3) / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, term = 0, enc = 0, d75 = 0, ov = 0, oc = 0, sw = 0;
  logic pt_a, pt_b, fwd_gate, syn_gate;

  int checks = 0, errors = 0, k = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pt_encoder #(.PERIOD_CLKS(P), .NOTCH_CLKS(N)) i_pt_encoder (
    .clk(clk), .rst(rst), .cyc_tick(tick), .term_req(term), .enc_sel(enc),
    .dmax75_sel(d75), .ov_flag(ov), .oc_flag(oc), .sw_neg(sw),
    .pt_a(pt_a), .pt_b(pt_b), .fwd_gate(fwd_gate), .syn_gate(syn_gate)
  );

  // cycle model built from the requirements
  int m_cnt, m_ph, m_n;
  bit m_enc, m_d75, m_fwd, m_syn, m_ref, te, stp, dm, ns;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = P; m_ph = 0; m_n = 0; m_enc = 0; m_d75 = 0; m_fwd = 0; m_syn = 0; m_ref = 0;
    end else begin
      te = term | oc | ov;
      ns = ov ? 1'b1 : tick ? 1'b0 : (!m_fwd && sw && m_ph != 0) ? 1'b1 : m_syn;
      dm = 0;
      if (tick) begin
        m_cnt = 0; m_enc = enc; m_d75 = d75; m_ph = 1; m_ref = 1;
        stp = te; m_fwd = !te;
      end else begin
        if (m_cnt < P) m_cnt++;
        dm = (m_ph == 1) && (m_cnt == (m_d75 ? D75 : D50));
        if (dm) m_ph = 2;
        if (m_cnt == D50) m_ref = 0;
        stp = m_fwd && te && !dm;
        m_fwd = m_fwd && !te && !dm;
      end
      if (dm) m_n = 0;
      else if (stp && m_enc) m_n = N;
      else if (tick) m_n = 0;
      else if (m_n > 0) m_n--;
      m_syn = ns;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (k=%0d, t=%0t)", tag, act, exp, k, $time);
    end
  endtask

  task automatic step(input bit t, input bit tr, input bit o_v, input bit o_c,
                      input bit s, input bit e, input bit d);
    bit ea, eb;
    @(negedge clk);
    tick = t; term = tr; ov = o_v; oc = o_c; sw = s; enc = e; d75 = d;
    @(posedge clk);
    #1;
    k = t ? 0 : k + 1;
    ea = m_enc ? (m_ph == 1 && m_n == 0) : m_fwd;
    eb = m_enc ? (m_ph == 2) : m_ref;
    chk(!m_enc ? "R9 line A" : (m_n != 0 ? "R5 line A" : "R3 line A"), pt_a, ea);
    chk(!m_enc ? "R9 line B" : "R3 line B", pt_b, eb);
    chk(ov ? "R11 forward" : "R2 forward", fwd_gate, m_fwd);
    chk(ov ? "R11 sync" : "R10 sync", syn_gate, m_syn);
  endtask

  task automatic idle_to(input int target, input bit e, input bit d);
    while (k < target) step(0, 0, 0, 0, 0, e, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset A", pt_a, 0); chk("R1 reset B", pt_b, 0);
    chk("R1 reset fwd", fwd_gate, 0); chk("R1 reset syn", syn_gate, 0);
    @(negedge clk); rst = 0;
    repeat (3) step(0, 0, 0, 0, 1, 1, 0);
    chk("R1 idle A", pt_a, 0); chk("R1 idle syn", syn_gate, 0);

    // encoded 50%, terminate, notch, ignored second terminate, sync gate
    step(1, 0, 0, 0, 0, 1, 0);
    chk("R2 fwd", fwd_gate, 1); chk("R2 A", pt_a, 1); chk("R2 B", pt_b, 0);
    idle_to(9, 1, 0);
    step(0, 1, 0, 0, 0, 1, 0);
    chk("R5 fwd off", fwd_gate, 0); chk("R5 notch A", pt_a, 0); chk("R5 notch B", pt_b, 0);
    idle_to(13, 1, 0);
    chk("R5 notch last", pt_a, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R5 notch over", pt_a, 1);
    step(0, 1, 0, 0, 0, 1, 0);
    chk("R7 no second notch", pt_a, 1);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R10 sync on", syn_gate, 1);
    idle_to(23, 1, 0);
    chk("R4 before dmax", pt_a, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R4 dmax A", pt_a, 0); chk("R3 neg B", pt_b, 1); chk("R10 sync held", syn_gate, 1);
    idle_to(P - 1, 1, 0);

    // encoded 75%, mode inputs changed mid-cycle, sw_neg during on-time
    step(1, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 1, 0);
    chk("R10 no sync while fwd", syn_gate, 0);
    idle_to(35, 1, 0);
    chk("R4 75 before", fwd_gate, 1); chk("R8 still pos", pt_a, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R4 75 dmax fwd", fwd_gate, 0); chk("R8 latched dmax", pt_b, 1);
    idle_to(P - 1, 1, 0);

    // zero duty
    step(1, 1, 0, 0, 0, 1, 0);
    chk("R6 fwd low", fwd_gate, 0); chk("R6 notch A", pt_a, 0); chk("R6 notch B", pt_b, 0);
    idle_to(3, 1, 0);
    chk("R6 notch still", pt_a, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R6 notch end", pt_a, 1);
    idle_to(P - 1, 1, 0);

    // standard mode, encoded select raised mid-cycle
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R9 A pwm", pt_a, 1); chk("R9 B clk", pt_b, 1);
    idle_to(4, 1, 0);
    step(0, 1, 0, 0, 0, 1, 0);
    chk("R9 A follows fwd", pt_a, 0);
    idle_to(10, 1, 0);
    chk("R8 mode latched", pt_b, 1);
    idle_to(23, 1, 0);
    chk("R9 B high", pt_b, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R9 B low", pt_b, 0);
    idle_to(P - 1, 0, 0);

    // overvoltage
    step(1, 0, 0, 0, 0, 1, 0);
    idle_to(2, 1, 0);
    step(0, 0, 1, 0, 0, 1, 0);
    chk("R11 sync", syn_gate, 1); chk("R11 fwd", fwd_gate, 0);
    idle_to(P - 1, 1, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    chk("R11 resume fwd", fwd_gate, 1); chk("R11 resume syn", syn_gate, 0);

    // overcurrent
    idle_to(1, 1, 0);
    step(0, 0, 0, 1, 0, 1, 0);
    chk("R12 fwd off", fwd_gate, 0);
    idle_to(P - 1, 1, 0);
    step(1, 0, 0, 1, 0, 1, 0);
    chk("R12 zero duty", fwd_gate, 0);
    idle_to(P - 1, 1, 0);

    // random periods
    for (int c = 0; c < 150; c++) begin
      int len;
      len = (($urandom % 8) == 0) ? P + 6 : P;
      for (int j = 0; j < len; j++) begin
        step(j == 0, ($urandom % 16) == 0, ($urandom % 64) == 0, ($urandom % 80) == 0,
             ($urandom % 3) == 0, 1'($urandom % 2), 1'($urandom % 2));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule